// File: doc/BRIEF.md
# Synchronous Burst Static Memory with Interleaved Beat Counter

This block is a clocked, byte-writable word memory meant to hold the data side of a processor's second-level cache. A base address is captured when either of two active-low address strobes is seen at a rising edge. A two-bit beat counter then walks the four words of the aligned group that holds that address. The next three beats come from a separate active-low advance input, so the cache controller does not have to present them.

The processor-side strobe always wins and always starts a read. The controller-side strobe starts a read or a write, chosen by the two byte-lane write enables. The chip enable is captured only when a base address loads, and that captured value then governs the whole burst. Holding advance high repeats the current beat, which gives a wait state. Read data comes from a register. A valid flag stands in for the high-impedance state of the data pins.

Top module: `burst_sram`

## Requirements
- R1: A synchronous active-high reset clears the beat counter, the captured enable and the read-valid state. After reset no write occurs and `rd_valid` stays low until a strobe loads an enabled base address.
- R2: When `pstb_n` is low at an edge, the block loads `addr_in` as the new base and clears the beat count. It then reads that word whatever `cstb_n` and `lane_we_n` are, and no memory lane is written.
- R3: When `cstb_n` is low and `pstb_n` is high at an edge, the block loads a new base the same way. If any bit of `lane_we_n` is low it writes `wdata` to that address in the same edge; otherwise it reads.
- R4: `ce_n` is captured only at an edge where a strobe loads a base. At every other edge the enable captured last stays in force, whatever `ce_n` is.
- R5: At an edge with both strobes high, `adv_n` low steps the beat count by one before the access. `adv_n` high keeps the count, so the same word is accessed again.
- R6: The accessed address keeps the upper base bits. Its two low bits are the base's low bits XOR the beat count. The count wraps modulo four, so the fifth beat returns to the starting word.
- R7: A write can follow a processor-strobe load. At the next edge both strobes are high and `lane_we_n` is not all ones, and `wdata` is written at the current beat address.
- R8: `lane_we_n[0]` guards bits 8:0 and `lane_we_n[1]` guards bits 17:9. Each lane is 8 data bits plus 1 parity bit. A lane whose enable is high keeps its old contents.
- R9: Read data appears on `rd_data` one edge after the access edge. `rd_valid` is high exactly when `oe_n` is low and the access at the previous edge was an enabled read.
- R10: While the captured enable is inactive, no lane is written and `rd_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | AW | Base word address, AW = clog2(DEPTH) |
| pstb_n | input | 1 | Processor-side address strobe, active low |
| cstb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Beat advance, active low |
| ce_n | input | 1 | Chip enable, active low, captured on base loads |
| lane_we_n | input | 2 | Byte-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low |
| wdata | input | 18 | Write word, two 9-bit lanes |
| rd_data | output | 18 | Registered read word, zero while not valid |
| rd_valid | output | 1 | Read data is being driven |

## Verification
The bench builds the block with DEPTH=64. At that size it can fill every word through controller-strobe writes before any read, so the reference model never has to predict an unwritten word. Random addresses can then fall anywhere in the array, including bursts that start at the top word and wrap inside its group. The small depth also lets a long random phase reach, many times over, the mixes of strobe priority, wait states, disabled bursts and single-lane writes.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;
    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        LOAD_NONE = 2'd0,
        LOAD_PROC = 2'd1,
        LOAD_CTRL = 2'd2
    } load_e;

    typedef struct packed {
        logic             act;
        logic             wr;
        logic [LANES-1:0] lane_we;
    } access_t;

    function automatic load_e classify(input logic p_n, input logic c_n);
        if (!p_n)      return LOAD_PROC;
        else if (!c_n) return LOAD_CTRL;
        else           return LOAD_NONE;
    endfunction

    function automatic logic [BEAT_W-1:0] beat_bits(input logic [BEAT_W-1:0] start,
                                                    input logic [BEAT_W-1:0] cnt);
        return start ^ cnt;
    endfunction

endpackage

// File: rtl/burst_sram_seq.sv
module burst_sram_seq
    import burst_sram_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr_in,
    input  logic              pstb_n,
    input  logic              cstb_n,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic [LANES-1:0]  lane_we_n,
    output logic [AW-1:0]     acc_addr,
    output access_t           acc,
    output logic [BEAT_W-1:0] beat_q,
    output logic              en_q
);

    logic [AW-1:0]     base_q, base_nxt;
    logic [BEAT_W-1:0] beat_nxt;
    logic              en_nxt;
    logic              wr_req;
    load_e             load;

    assign load = classify(pstb_n, cstb_n);

    always_comb begin
        base_nxt = base_q;
        beat_nxt = beat_q;
        en_nxt   = en_q;
        wr_req   = 1'b0;
        case (load)
            LOAD_PROC: begin
                base_nxt = addr_in;
                beat_nxt = '0;
                en_nxt   = ~ce_n;
                wr_req   = 1'b0;
            end
            LOAD_CTRL: begin
                base_nxt = addr_in;
                beat_nxt = '0;
                en_nxt   = ~ce_n;
                wr_req   = ~&lane_we_n;
            end
            default: begin
                if (!adv_n) beat_nxt = beat_q + 1'b1;
                wr_req = ~&lane_we_n;
            end
        endcase
    end

    always_comb begin
        acc_addr     = {base_nxt[AW-1:BEAT_W], beat_bits(base_nxt[BEAT_W-1:0], beat_nxt)};
        acc.act      = en_nxt;
        acc.wr       = wr_req & en_nxt;
        acc.lane_we  = (wr_req & en_nxt) ? ~lane_we_n : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            beat_q <= '0;
            en_q   <= 1'b0;
        end else begin
            base_q <= base_nxt;
            beat_q <= beat_nxt;
            en_q   <= en_nxt;
        end
    end

endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array
    import burst_sram_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [AW-1:0]     addr,
    input  logic [LANES-1:0]  lane_we,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g])
                store[addr] <= wdata[g*LANE_W +: LANE_W];
            if (rd_en)
                rdata[g*LANE_W +: LANE_W] <= store[addr];
        end
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr_in,
    input  logic              pstb_n,
    input  logic              cstb_n,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic [1:0]        lane_we_n,
    input  logic              oe_n,
    input  logic [17:0]       wdata,
    output logic [17:0]       rd_data,
    output logic              rd_valid
);

    logic [AW-1:0]     acc_addr;
    access_t           acc;
    logic [BEAT_W-1:0] beat_q;
    logic              en_q;
    logic [LANES-1:0]  lane_we_int;
    logic [WORD_W-1:0] arr_rdata;
    logic              rd_done_q;

    burst_sram_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .addr_in   (addr_in),
        .pstb_n    (pstb_n),
        .cstb_n    (cstb_n),
        .adv_n     (adv_n),
        .ce_n      (ce_n),
        .lane_we_n (lane_we_n),
        .acc_addr  (acc_addr),
        .acc       (acc),
        .beat_q    (beat_q),
        .en_q      (en_q)
    );

    assign lane_we_int = rst ? '0 : acc.lane_we;

    burst_sram_array #(.DEPTH(DEPTH)) u_array (
        .clk     (clk),
        .addr    (acc_addr),
        .lane_we (lane_we_int),
        .rd_en   (acc.act & ~acc.wr & ~rst),
        .wdata   (wdata),
        .rdata   (arr_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) rd_done_q <= 1'b0;
        else     rd_done_q <= acc.act & ~acc.wr;
    end

    assign rd_valid = rd_done_q & ~oe_n;
    assign rd_data  = rd_valid ? arr_rdata : '0;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk (
    input logic       clk,
    input logic       rst,
    input logic       pstb_n,
    input logic       cstb_n,
    input logic       adv_n,
    input logic       oe_n,
    input logic [1:0] lane_we_n,
    input logic       rd_valid,
    input logic [1:0] beat_q,
    input logic       en_q,
    input logic [1:0] lane_we_int
);

    AST_VALID_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !oe_n); // R9

    AST_PROC_FORCES_READ: assert property (@(posedge clk) disable iff (rst)
        !pstb_n |-> lane_we_int == 2'b00); // R2

    AST_LOAD_CLEARS_BEAT: assert property (@(posedge clk) disable iff (rst)
        (!pstb_n || !cstb_n) |=> beat_q == 2'd0); // R6

    AST_WAIT_HOLDS_BEAT: assert property (@(posedge clk) disable iff (rst)
        (pstb_n && cstb_n && adv_n) |=> $stable(beat_q)); // R5

    AST_ADV_STEPS_BEAT: assert property (@(posedge clk) disable iff (rst)
        (pstb_n && cstb_n && !adv_n) |=> beat_q == $past(beat_q) + 2'd1); // R5

    AST_ENABLE_HELD: assert property (@(posedge clk) disable iff (rst)
        (pstb_n && cstb_n) |=> $stable(en_q)); // R4

    AST_DISABLED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!en_q && pstb_n && cstb_n) |-> lane_we_int == 2'b00); // R10

    AST_LANE_FOLLOWS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (lane_we_int & lane_we_n) == 2'b00); // R8

endmodule

bind burst_sram burst_sram_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pstb_n      (pstb_n),
    .cstb_n      (cstb_n),
    .adv_n       (adv_n),
    .oe_n        (oe_n),
    .lane_we_n   (lane_we_n),
    .rd_valid    (rd_valid),
    .beat_q      (beat_q),
    .en_q        (en_q),
    .lane_we_int (lane_we_int)
);

// File: tb/burst_sram_bench.sv
`timescale 1ns/1ps
module burst_sram_bench;

    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr_in;
    logic          pstb_n, cstb_n, adv_n, ce_n, oe_n;
    logic [1:0]    lane_we_n;
    logic [17:0]   wdata;
    logic [17:0]   rd_data;
    logic          rd_valid;

    always #5 clk = ~clk;

    burst_sram #(.DEPTH(DEPTH)) u_burst_sram (
        .clk       (clk),
        .rst       (rst),
        .addr_in   (addr_in),
        .pstb_n    (pstb_n),
        .cstb_n    (cstb_n),
        .adv_n     (adv_n),
        .ce_n      (ce_n),
        .lane_we_n (lane_we_n),
        .oe_n      (oe_n),
        .wdata     (wdata),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    int    checks = 0;
    int    failures = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_mem [DEPTH];
    int m_base = 0;
    int m_cnt = 0;
    int m_en = 0;
    int m_rdv = 0;
    int m_rdata = 0;

    task automatic model_update();
        int wr;
        int a;
        if (rst) begin
            m_base = 0; m_cnt = 0; m_en = 0; m_rdv = 0;
            return;
        end
        wr = 0;
        if (!pstb_n) begin
            m_base = int'(addr_in); m_cnt = 0; m_en = !ce_n;
        end else if (!cstb_n) begin
            m_base = int'(addr_in); m_cnt = 0; m_en = !ce_n;
            wr = (lane_we_n != 2'b11);
        end else begin
            if (!adv_n) m_cnt = (m_cnt + 1) % 4;
            wr = (lane_we_n != 2'b11);
        end
        a = (m_base & ~3) | ((m_base & 3) ^ m_cnt);
        if (m_en != 0 && wr != 0) begin
            if (!lane_we_n[0]) m_mem[a] = (m_mem[a] & 'h3FE00) | (int'(wdata) & 'h1FF);
            if (!lane_we_n[1]) m_mem[a] = (m_mem[a] & 'h001FF) | (int'(wdata) & 'h3FE00);
            m_rdv = 0;
        end else if (m_en != 0) begin
            m_rdv = 1;
            m_rdata = m_mem[a];
        end else begin
            m_rdv = 0;
        end
    endtask

    task automatic compare();
        logic exp_vld;
        exp_vld = (m_rdv != 0) && !oe_n;
        checks++;
        if (rd_valid !== exp_vld) begin
            failures++;
            $display("FAIL %s rd_valid actual=%0b expected=%0b t=%0t", cur_req, rd_valid, exp_vld, $time);
        end
        if (exp_vld) begin
            checks++;
            if (rd_data !== 18'(m_rdata)) begin
                failures++;
                $display("FAIL %s rd_data actual=%05h expected=%05h t=%0t", cur_req, rd_data, m_rdata, $time);
            end
        end
    endtask

    task automatic cyc(input logic p, input logic c, input logic adv, input logic ce,
                       input logic [1:0] we, input logic oe, input int adr, input int d);
        pstb_n = p; cstb_n = c; adv_n = adv; ce_n = ce;
        lane_we_n = we; oe_n = oe; addr_in = AW'(adr); wdata = 18'(d);
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    // idle continuation with outputs enabled
    task automatic idle(input logic adv);
        cyc(1, 1, adv, 0, 2'b11, 0, 0, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                failures++;
                $display("FAIL R1 watchdog actual=running expected=finished");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        int lfsr;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
        rst = 1'b1;
        pstb_n = 1; cstb_n = 1; adv_n = 1; ce_n = 0; lane_we_n = 2'b11;
        oe_n = 0; addr_in = '0; wdata = '0;
        @(negedge clk);

        // R1: reset holds everything idle
        cur_req = "R1";
        cyc(1, 1, 1, 0, 2'b11, 0, 0, 0);
        cyc(1, 1, 0, 0, 2'b00, 0, 5, 'h3FFFF);
        rst = 1'b0;
        // R1 / R10: no strobe yet, continuation writes and reads do nothing
        cyc(1, 1, 0, 0, 2'b00, 0, 5, 'h3FFFF);
        cyc(1, 1, 0, 0, 2'b11, 0, 5, 0);
        cur_req = "R10";
        cyc(1, 1, 1, 0, 2'b11, 0, 0, 0);

        // R3: fill every word through controller-strobe writes
        cur_req = "R3";
        for (int i = 0; i < DEPTH; i++)
            cyc(1, 0, 1, 0, 2'b00, 0, i, (i * 1237 + 77) & 'h3FFFF);
        // R3: controller strobe with no lane enable reads
        cyc(1, 0, 1, 0, 2'b11, 0, 9, 0);
        idle(1);

        // R2: processor strobe reads even with write enables and controller strobe low
        cur_req = "R2";
        cyc(0, 0, 1, 0, 2'b00, 0, 13, 'h15555);
        idle(1);
        cyc(0, 1, 0, 0, 2'b00, 0, 13, 'h2AAAA);
        idle(1);

        // R5 / R6: interleaved burst from 13 with wait states and wrap
        cur_req = "R6";
        cyc(0, 1, 1, 0, 2'b11, 0, 13, 0);
        idle(0);
        cur_req = "R5";
        idle(1);
        idle(1);
        cur_req = "R6";
        idle(0);
        idle(0);
        idle(0);
        idle(0);
        // burst starting at the top word
        cyc(0, 1, 1, 0, 2'b11, 0, 63, 0);
        idle(0); idle(0); idle(0); idle(0);

        // R4: disabled load, later ce_n low on continuation is ignored
        cur_req = "R4";
        cyc(1, 0, 1, 1, 2'b11, 0, 20, 0);
        cyc(1, 1, 0, 0, 2'b00, 0, 0, 'h11111);
        cyc(1, 1, 0, 0, 2'b11, 0, 0, 0);
        cur_req = "R10";
        cyc(1, 1, 1, 0, 2'b01, 0, 0, 'h22222);
        cur_req = "R4";
        cyc(0, 1, 1, 0, 2'b11, 0, 20, 0);
        idle(0); idle(0); idle(0);
        // enabled load, ce_n high afterwards keeps the burst active
        cyc(0, 1, 1, 0, 2'b11, 0, 24, 0);
        cyc(1, 1, 0, 1, 2'b11, 0, 0, 0);
        cyc(1, 1, 0, 1, 2'b11, 0, 0, 0);

        // R7: two-cycle write after a processor-strobe load
        cur_req = "R7";
        cyc(0, 1, 1, 0, 2'b11, 0, 40, 0);
        cyc(1, 1, 1, 0, 2'b00, 0, 0, 'h0ABCD);
        cyc(0, 1, 1, 0, 2'b11, 0, 40, 0);
        idle(1);

        // R8: single-lane writes
        cur_req = "R8";
        cyc(1, 0, 1, 0, 2'b10, 0, 41, 'h3FFFF);
        cyc(1, 0, 1, 0, 2'b01, 0, 42, 'h3FFFF);
        cyc(0, 1, 1, 0, 2'b11, 0, 41, 0);
        cyc(0, 1, 1, 0, 2'b11, 0, 42, 0);
        idle(1);

        // R3 / R6: burst write from 50 (beats 50,51,48,49)
        cur_req = "R3";
        cyc(1, 0, 1, 0, 2'b00, 0, 50, 'h00101);
        cyc(1, 1, 0, 0, 2'b00, 0, 0, 'h00202);
        cyc(1, 1, 0, 0, 2'b00, 0, 0, 'h00303);
        cyc(1, 1, 0, 0, 2'b00, 0, 0, 'h00404);
        cyc(0, 1, 1, 0, 2'b11, 0, 50, 0);
        idle(0); idle(0); idle(0);

        // R9: output enable high hides a read
        cur_req = "R9";
        cyc(0, 1, 1, 0, 2'b11, 1, 7, 0);
        cyc(1, 1, 1, 0, 2'b11, 1, 0, 0);
        cyc(1, 1, 1, 0, 2'b11, 0, 0, 0);

        // R5: mixed random traffic
        cur_req = "R5";
        lfsr = 32'h1ACE5;
        for (int k = 0; k < 600; k++) begin
            logic p, c, adv, ce, oe;
            logic [1:0] we;
            lfsr = (lfsr * 1103515245 + 12345) & 32'h7FFFFFFF;
            p   = (lfsr[3:0] == 4'd0);
            c   = (lfsr[6:4] != 3'd0);
            adv = lfsr[7];
            ce  = (lfsr[10:8] == 3'd0);
            oe  = (lfsr[13:11] == 3'd0);
            we  = lfsr[15:14];
            cyc(!p, c, adv, ce, we, oe, (lfsr >>> 16) & (DEPTH - 1), (lfsr >>> 5) & 'h3FFFF);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule